// File: doc/BRIEF.md
# Converter Control and Conversion Sequencer

This block is the register front end of a single analog-to-digital converter channel group. A 32-bit register bus programs its control fields, its channel sequence and its trigger mode, and reads back status and results. The block powers the converter up and waits a fixed settling time. It then launches a regular conversion sequence, started either by software or by a chosen edge of an external trigger. For each slot of the sequence it hands a channel number to the converter and collects a 12-bit result.

The converter is reached through a short handshake. The block pulses a start strobe with the channel number held alongside it. Later the converter returns a done strobe together with the result. Results land in a data register. An end-of-conversion flag, and an interrupt gated by an enable bit, tell software that a result is ready. Several copies of the block can share one bus window. Each copy answers only in the 256-byte slot selected by its base parameter.

Top module: `adcif_top`

## Requirements
- R1: After reset every register reads 0, `irq_o` is low and `conv_start_o` is low.
- R2: An access counts only when `bus_addr_i[11:8]` equals `INST_BASE[11:8]`. Within the window the status register is at 0x00, control A at 0x04, control B at 0x08, sequence registers at 0x2C, 0x30 and 0x34, and the result at 0x4C. Writes to other windows change nothing. Reads of other windows and of any other offset return 0.
- R3: Control A keeps the scan enable in bit 8 and the interrupt enable in bit 5. Control B keeps power-on in bit 0, the per-conversion flag select in bit 10, the trigger mode in bits 29:28 (00 off, 01 rising, 10 falling, 11 both edges) and the software start in bit 30. Unimplemented bits read 0.
- R4: After power-on is set, no conversion starts for `STAB_CYCLES` cycles. A software start written during that time is held and is launched once the wait ends.
- R5: A software start takes effect only when the trigger mode is 00; otherwise the write is dropped and bit 30 reads 0. Once a start is accepted, bit 30 reads 0.
- R6: With a trigger mode other than 00, the selected edge of `ext_trig_i` starts a sequence when the sequencer is idle. Other edges do nothing.
- R7: Register 0x2C bits 23:20 hold the number of conversions minus one. Slot k takes its channel from a 5-bit field: slots 0-5 from 0x34 bits 5k+4:5k, slots 6-11 from 0x30, slots 12-15 from 0x2C bits 19:0. With scan enabled, slots 0 to length are converted in order. With scan disabled, only slot 0 is converted.
- R8: Each result is stored right-aligned in bits 11:0 of the result register, and its upper bits read 0.
- R9: Status bit 1 (end of conversion) is set after every conversion when bit 10 of control B is 1, and otherwise only after the last conversion of the sequence. Reading the result register clears it. A new result arriving in the same cycle as that read leaves the flag set.
- R10: Status bit 4 is set when a sequence starts and is cleared by writing 0 to it. Writing 1 to bit 4 or bit 1 leaves that bit unchanged.
- R11: `irq_o` is high exactly while status bit 1 and the interrupt enable are both 1.
- R12: Clearing power-on aborts the sequence. No further start strobe is issued, a late done strobe is ignored, and status bit 4 is cleared.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bus_addr_i | input | 12 | Register byte address |
| bus_wr_i | input | 1 | Write strobe |
| bus_rd_i | input | 1 | Read strobe (result read clears end of conversion) |
| bus_wdata_i | input | 32 | Write data |
| bus_rdata_o | output | 32 | Read data, combinational, 0 when not selected |
| ext_trig_i | input | 1 | External trigger level |
| conv_start_o | output | 1 | One-cycle start strobe to the converter |
| conv_ch_o | output | 5 | Channel for the current conversion |
| conv_done_i | input | 1 | Converter done strobe |
| conv_result_i | input | 12 | Converter result, valid with done |
| irq_o | output | 1 | End-of-conversion interrupt |

## Verification
The clear of the end-of-conversion flag by a result read can fall in the same cycle as the set caused by a new result. To provoke this, the bench takes over the converter and raises `conv_done_i` on the clock edge at which a read of 0x4C is active. It then expects status bit 1 to remain 1 and the result register to hold the new value. A second collision comes from a status write of 0 to bit 4 and a sequence start. The bench avoids driving that one and judges only separate writes.

// File: rtl/adcif_pkg.sv
package adcif_pkg;
  localparam int NUM_SLOTS  = 16;
  localparam int CH_W       = 5;
  localparam int LEN_W      = 4;
  localparam int SLOTS_REG  = 6;
  localparam int SEQ_FLD_W  = SLOTS_REG * CH_W;
  localparam int SEQ1_W     = (NUM_SLOTS - 2 * SLOTS_REG) * CH_W + LEN_W;

  localparam logic [7:0] OFS_STAT = 8'h00;
  localparam logic [7:0] OFS_CTLA = 8'h04;
  localparam logic [7:0] OFS_CTLB = 8'h08;
  localparam logic [7:0] OFS_SEQ1 = 8'h2C;
  localparam logic [7:0] OFS_SEQ2 = 8'h30;
  localparam logic [7:0] OFS_SEQ3 = 8'h34;
  localparam logic [7:0] OFS_DATA = 8'h4C;

  typedef enum logic [1:0] {
    TRIG_OFF  = 2'b00,
    TRIG_RISE = 2'b01,
    TRIG_FALL = 2'b10,
    TRIG_BOTH = 2'b11
  } trig_mode_e;

  typedef enum logic [1:0] {
    SQ_IDLE = 2'd0,
    SQ_REQ  = 2'd1,
    SQ_WAIT = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic       scan;
    logic       eocie;
    logic       pwr;
    logic       eoc_each;
    trig_mode_e trig;
  } ctrl_t;
endpackage

// File: rtl/adcif_regs.sv
module adcif_regs
  import adcif_pkg::*;
#(
  parameter int                ADDR_W    = 12,
  parameter logic [ADDR_W-1:0] INST_BASE = '0,
  parameter int                RES_W     = 12
) (
  input  logic                          clk_i,
  input  logic                          rst_ni,
  input  logic [ADDR_W-1:0]             bus_addr_i,
  input  logic                          bus_wr_i,
  input  logic                          bus_rd_i,
  input  logic [31:0]                   bus_wdata_i,
  output logic [31:0]                   bus_rdata_o,
  output ctrl_t                         ctrl_o,
  output logic                          sw_pend_o,
  output logic [LEN_W-1:0]              seq_len_o,
  output logic [NUM_SLOTS-1:0][CH_W-1:0] slots_o,
  input  logic                          go_i,
  input  logic                          sw_ack_i,
  input  logic                          res_valid_i,
  input  logic                          res_last_i,
  input  logic [RES_W-1:0]              res_data_i,
  output logic                          irq_o
);
  localparam int WIN_LSB = 8;

  logic                  hit;
  logic [7:0]            ofs;
  logic                  wr_stat, wr_ctla, wr_ctlb, wr_seq1, wr_seq2, wr_seq3, rd_data;
  ctrl_t                 ctrl_q;
  logic                  sw_pend_q, eoc_q, strt_q;
  logic [SEQ1_W-1:0]     seq1_q;
  logic [SEQ_FLD_W-1:0]  seq2_q, seq3_q;
  logic [RES_W-1:0]      data_q;
  logic                  unused_wdata;

  assign hit     = bus_addr_i[ADDR_W-1:WIN_LSB] == INST_BASE[ADDR_W-1:WIN_LSB];
  assign ofs     = bus_addr_i[7:0];
  assign wr_stat = bus_wr_i && hit && ofs == OFS_STAT;
  assign wr_ctla = bus_wr_i && hit && ofs == OFS_CTLA;
  assign wr_ctlb = bus_wr_i && hit && ofs == OFS_CTLB;
  assign wr_seq1 = bus_wr_i && hit && ofs == OFS_SEQ1;
  assign wr_seq2 = bus_wr_i && hit && ofs == OFS_SEQ2;
  assign wr_seq3 = bus_wr_i && hit && ofs == OFS_SEQ3;
  assign rd_data = bus_rd_i && hit && ofs == OFS_DATA;
  assign unused_wdata = ^bus_wdata_i;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q <= '0;
      seq1_q <= '0;
      seq2_q <= '0;
      seq3_q <= '0;
    end else begin
      if (wr_ctla) begin
        ctrl_q.scan  <= bus_wdata_i[8];
        ctrl_q.eocie <= bus_wdata_i[5];
      end
      if (wr_ctlb) begin
        ctrl_q.pwr      <= bus_wdata_i[0];
        ctrl_q.eoc_each <= bus_wdata_i[10];
        ctrl_q.trig     <= trig_mode_e'(bus_wdata_i[29:28]);
      end
      if (wr_seq1) seq1_q <= bus_wdata_i[SEQ1_W-1:0];
      if (wr_seq2) seq2_q <= bus_wdata_i[SEQ_FLD_W-1:0];
      if (wr_seq3) seq3_q <= bus_wdata_i[SEQ_FLD_W-1:0];
    end
  end

  // pending software start: only with trigger off and power on
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sw_pend_q <= 1'b0;
    end else if (wr_ctlb) begin
      sw_pend_q <= (bus_wdata_i[30] | (sw_pend_q & ~sw_ack_i))
                   & (bus_wdata_i[29:28] == 2'b00) & bus_wdata_i[0];
    end else if (sw_ack_i || !ctrl_q.pwr) begin
      sw_pend_q <= 1'b0;
    end
  end

  // set beats clear on both flags
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      eoc_q  <= 1'b0;
      strt_q <= 1'b0;
      data_q <= '0;
    end else begin
      if (res_valid_i) data_q <= res_data_i;
      if (res_valid_i && (ctrl_q.eoc_each || res_last_i)) eoc_q <= 1'b1;
      else if (rd_data || (wr_stat && !bus_wdata_i[1]))   eoc_q <= 1'b0;
      if (!ctrl_q.pwr)                        strt_q <= 1'b0;
      else if (go_i)                          strt_q <= 1'b1;
      else if (wr_stat && !bus_wdata_i[4])    strt_q <= 1'b0;
    end
  end

  for (genvar k = 0; k < NUM_SLOTS; k++) begin : g_slot
    if (k < SLOTS_REG) begin : g_s3
      assign slots_o[k] = seq3_q[CH_W*k +: CH_W];
    end else if (k < 2 * SLOTS_REG) begin : g_s2
      assign slots_o[k] = seq2_q[CH_W*(k-SLOTS_REG) +: CH_W];
    end else begin : g_s1
      assign slots_o[k] = seq1_q[CH_W*(k-2*SLOTS_REG) +: CH_W];
    end
  end

  assign seq_len_o = seq1_q[SEQ1_W-1 -: LEN_W];
  assign ctrl_o    = ctrl_q;
  assign sw_pend_o = sw_pend_q;
  assign irq_o     = eoc_q & ctrl_q.eocie;

  always_comb begin
    bus_rdata_o = '0;
    if (bus_rd_i && hit) begin
      unique case (ofs)
        OFS_STAT: bus_rdata_o = {27'b0, strt_q, 2'b0, eoc_q, 1'b0};
        OFS_CTLA: bus_rdata_o = {23'b0, ctrl_q.scan, 2'b0, ctrl_q.eocie, 5'b0};
        OFS_CTLB: bus_rdata_o = {1'b0, sw_pend_q, ctrl_q.trig, 17'b0,
                                 ctrl_q.eoc_each, 9'b0, ctrl_q.pwr};
        OFS_SEQ1: bus_rdata_o = {{(32-SEQ1_W){1'b0}}, seq1_q};
        OFS_SEQ2: bus_rdata_o = {{(32-SEQ_FLD_W){1'b0}}, seq2_q};
        OFS_SEQ3: bus_rdata_o = {{(32-SEQ_FLD_W){1'b0}}, seq3_q};
        OFS_DATA: bus_rdata_o = {{(32-RES_W){1'b0}}, data_q};
        default:  bus_rdata_o = '0;
      endcase
    end
  end

  a_r9_eoc_on_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_i && (ctrl_q.eoc_each || res_last_i) |=> eoc_q);
  a_r12_strt_drop: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ctrl_q.pwr |=> !strt_q);
  a_r5_ack_clears: assert property (@(posedge clk_i) disable iff (!rst_ni)
    sw_ack_i && !wr_ctlb |=> !sw_pend_q);
  a_r10_start_sets: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i && ctrl_q.pwr |=> strt_q);
endmodule

// File: rtl/adcif_trig.sv
module adcif_trig
  import adcif_pkg::*;
#(
  parameter int STAB_CYCLES = 8
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic       pwr_i,
  input  trig_mode_e trig_mode_i,
  input  logic       sw_pend_i,
  input  logic       seq_idle_i,
  input  logic       ext_trig_i,
  output logic       go_o,
  output logic       sw_ack_o
);
  localparam int CNT_W = $clog2(STAB_CYCLES + 1);

  logic [CNT_W-1:0] cnt_q;
  logic             ext_q, ready, rise, fall, edge_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= CNT_W'(STAB_CYCLES);
      ext_q <= 1'b0;
    end else begin
      ext_q <= ext_trig_i;
      if (!pwr_i)           cnt_q <= CNT_W'(STAB_CYCLES);
      else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
    end
  end

  assign ready = pwr_i && cnt_q == '0;
  assign rise  = ext_trig_i & ~ext_q;
  assign fall  = ~ext_trig_i & ext_q;

  always_comb begin
    unique case (trig_mode_i)
      TRIG_RISE: edge_hit = rise;
      TRIG_FALL: edge_hit = fall;
      TRIG_BOTH: edge_hit = rise | fall;
      default:   edge_hit = 1'b0;
    endcase
  end

  assign go_o     = ready && seq_idle_i &&
                    (trig_mode_i == TRIG_OFF ? sw_pend_i : edge_hit);
  assign sw_ack_o = go_o && trig_mode_i == TRIG_OFF;

  // STAB_CYCLES is expected to be at least 2
  a_r4_holdoff: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(pwr_i) |=> !go_o);
  a_r6_go_needs_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !pwr_i |-> !go_o);
endmodule

// File: rtl/adcif_seq.sv
module adcif_seq
  import adcif_pkg::*;
#(
  parameter int RES_W = 12
) (
  input  logic                           clk_i,
  input  logic                           rst_ni,
  input  logic                           go_i,
  input  logic                           abort_i,
  input  logic                           scan_i,
  input  logic [LEN_W-1:0]               len_i,
  input  logic [NUM_SLOTS-1:0][CH_W-1:0] slots_i,
  output logic                           conv_start_o,
  output logic [CH_W-1:0]                conv_ch_o,
  input  logic                           conv_done_i,
  input  logic [RES_W-1:0]               conv_result_i,
  output logic                           idle_o,
  output logic                           res_valid_o,
  output logic                           res_last_o,
  output logic [RES_W-1:0]               res_data_o
);
  seq_state_e       state_q;
  logic [LEN_W-1:0] idx_q, last_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
      last_q  <= '0;
    end else if (abort_i) begin
      state_q <= SQ_IDLE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        SQ_IDLE: if (go_i) begin
          state_q <= SQ_REQ;
          idx_q   <= '0;
          last_q  <= scan_i ? len_i : '0;
        end
        SQ_REQ: state_q <= SQ_WAIT;
        SQ_WAIT: if (conv_done_i) begin
          if (idx_q == last_q) begin
            state_q <= SQ_IDLE;
          end else begin
            state_q <= SQ_REQ;
            idx_q   <= idx_q + 1'b1;
          end
        end
        default: state_q <= SQ_IDLE;
      endcase
    end
  end

  assign conv_start_o = state_q == SQ_REQ;
  assign conv_ch_o    = slots_i[idx_q];
  assign idle_o       = state_q == SQ_IDLE;
  assign res_valid_o  = state_q == SQ_WAIT && conv_done_i && !abort_i;
  assign res_last_o   = idx_q == last_q;
  assign res_data_o   = conv_result_i;

  a_r7_start_pulse: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |=> !conv_start_o);
  a_r12_abort_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    abort_i |=> idle_o && !conv_start_o);
  a_r7_go_when_idle: assert property (@(posedge clk_i) disable iff (!rst_ni)
    go_i |-> idle_o);
  a_r8_single_result: assert property (@(posedge clk_i) disable iff (!rst_ni)
    res_valid_o |=> !res_valid_o);
endmodule

// File: rtl/adcif_top.sv
module adcif_top
  import adcif_pkg::*;
#(
  parameter int                ADDR_W      = 12,
  parameter logic [ADDR_W-1:0] INST_BASE   = 12'h000,
  parameter int                STAB_CYCLES = 8,
  parameter int                RES_W       = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [ADDR_W-1:0] bus_addr_i,
  input  logic              bus_wr_i,
  input  logic              bus_rd_i,
  input  logic [31:0]       bus_wdata_i,
  output logic [31:0]       bus_rdata_o,
  input  logic              ext_trig_i,
  output logic              conv_start_o,
  output logic [CH_W-1:0]   conv_ch_o,
  input  logic              conv_done_i,
  input  logic [RES_W-1:0]  conv_result_i,
  output logic              irq_o
);
  ctrl_t                         ctrl;
  logic                          sw_pend, go, sw_ack, seq_idle;
  logic                          res_valid, res_last;
  logic [RES_W-1:0]              res_data;
  logic [LEN_W-1:0]              seq_len;
  logic [NUM_SLOTS-1:0][CH_W-1:0] slots;

  adcif_regs #(.ADDR_W(ADDR_W), .INST_BASE(INST_BASE), .RES_W(RES_W)) u_regs (
    .clk_i, .rst_ni, .bus_addr_i, .bus_wr_i, .bus_rd_i, .bus_wdata_i, .bus_rdata_o,
    .ctrl_o(ctrl), .sw_pend_o(sw_pend), .seq_len_o(seq_len), .slots_o(slots),
    .go_i(go), .sw_ack_i(sw_ack), .res_valid_i(res_valid), .res_last_i(res_last),
    .res_data_i(res_data), .irq_o
  );

  adcif_trig #(.STAB_CYCLES(STAB_CYCLES)) u_trig (
    .clk_i, .rst_ni, .pwr_i(ctrl.pwr), .trig_mode_i(ctrl.trig), .sw_pend_i(sw_pend),
    .seq_idle_i(seq_idle), .ext_trig_i, .go_o(go), .sw_ack_o(sw_ack)
  );

  adcif_seq #(.RES_W(RES_W)) u_seq (
    .clk_i, .rst_ni, .go_i(go), .abort_i(!ctrl.pwr), .scan_i(ctrl.scan),
    .len_i(seq_len), .slots_i(slots), .conv_start_o, .conv_ch_o, .conv_done_i,
    .conv_result_i, .idle_o(seq_idle), .res_valid_o(res_valid),
    .res_last_o(res_last), .res_data_o(res_data)
  );

  a_r11_irq_needs_enable: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> ctrl.eocie);
  a_r4_start_needs_power: assert property (@(posedge clk_i) disable iff (!rst_ni)
    conv_start_o |-> ctrl.pwr);
endmodule

// File: tb/adcif_top_bench.sv
module adcif_top_bench;
  localparam int CLK_P = 10;
  localparam int STAB  = 8;
  localparam logic [11:0] BASE = 12'h100;

  logic        clk = 1'b0, rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic        wr = 1'b0, rd = 1'b0;
  logic [31:0] wdata = '0, rdata;
  logic        ext_trig = 1'b0;
  logic        conv_start, conv_done = 1'b0, irq;
  logic [4:0]  conv_ch;
  logic [11:0] conv_res = '0;

  int n_chk = 0, n_fail = 0;
  bit finished = 0;
  bit auto_en = 1;
  int lat = 2;
  int n_started = 0, n_done = 0;
  logic [4:0]  ch_log [16];
  logic [11:0] last_res = '0;

  always #(CLK_P/2) clk = ~clk;

  adcif_top #(.INST_BASE(BASE), .STAB_CYCLES(STAB)) u_adcif_top (
    .clk_i(clk), .rst_ni(rst_n), .bus_addr_i(addr), .bus_wr_i(wr), .bus_rd_i(rd),
    .bus_wdata_i(wdata), .bus_rdata_o(rdata), .ext_trig_i(ext_trig),
    .conv_start_o(conv_start), .conv_ch_o(conv_ch), .conv_done_i(conv_done),
    .conv_result_i(conv_res), .irq_o(irq)
  );

  // converter model
  initial begin
    forever begin
      @(negedge clk);
      while (auto_en && conv_start) begin
        if (n_started < 16) ch_log[n_started] = conv_ch;
        n_started++;
        repeat (lat) @(negedge clk);
        conv_res  = 12'($urandom);
        last_res  = conv_res;
        conv_done = 1'b1;
        @(negedge clk);
        conv_done = 1'b0;
        n_done++;
      end
    end
  end

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic bus_write(input logic [11:0] a, input logic [31:0] d);
    @(negedge clk); addr = a; wdata = d; wr = 1'b1;
    @(negedge clk); wr = 1'b0;
  endtask

  task automatic bus_read(input logic [11:0] a, output logic [31:0] d);
    @(negedge clk); addr = a; rd = 1'b1;
    #1 d = rdata;
    @(negedge clk); rd = 1'b0;
  endtask

  task automatic wait_done(input int target);
    for (int i = 0; i < 3000 && n_done < target; i++) @(negedge clk);
    repeat (2) @(negedge clk);
  endtask

  function automatic logic [31:0] pack_seq(input int reg_sel, input logic [4:0] s [16], input int len);
    logic [31:0] v = '0;
    for (int k = 0; k < 16; k++) begin
      if (reg_sel == 3 && k < 6)            v[5*k +: 5] = s[k];
      if (reg_sel == 2 && k >= 6 && k < 12) v[5*(k-6) +: 5] = s[k];
      if (reg_sel == 1 && k >= 12)          v[5*(k-12) +: 5] = s[k];
    end
    if (reg_sel == 1) v[23:20] = 4'(len);
    return v;
  endfunction

  // program sequence, start by software, check order and final result
  task automatic run_seq(input bit scan, input bit each, input int len, input logic [4:0] s [16]);
    logic [31:0] d;
    int cnt;
    cnt = scan ? len + 1 : 1;
    bus_write(BASE + 12'h34, pack_seq(3, s, len));
    bus_write(BASE + 12'h30, pack_seq(2, s, len));
    bus_write(BASE + 12'h2C, pack_seq(1, s, len));
    bus_write(BASE + 12'h04, {23'b0, scan, 8'b0});
    n_started = 0; n_done = 0;
    bus_write(BASE + 12'h08, 32'h4000_0001 | (32'(each) << 10));
    wait_done(cnt);
    chk("R7 conversion count", 32'(n_started), 32'(cnt));
    for (int k = 0; k < cnt; k++) chk("R7 channel order", 32'(ch_log[k]), 32'(s[k]));
    bus_read(BASE + 12'h08, d);
    chk("R5 start bit reads 0 after accept", {31'b0, d[30]}, 32'h0);
    bus_read(BASE + 12'h00, d);
    chk("R9 R10 status after sequence", d, 32'h12);
    bus_read(BASE + 12'h4C, d);
    chk("R8 result register", d, {20'b0, last_res});
    bus_read(BASE + 12'h00, d);
    chk("R9 result read clears flag", d, 32'h10);
    bus_write(BASE + 12'h00, 32'h0);
  endtask

  initial begin
    logic [31:0] d;
    logic [4:0]  s [16];
    int cyc;
    void'($urandom(32'd4711));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset values
    chk("R1 irq after reset", {31'b0, irq}, 32'h0);
    chk("R1 start after reset", {31'b0, conv_start}, 32'h0);
    foreach (s[k]) s[k] = '0;
    bus_read(BASE + 12'h00, d); chk("R1 status reset", d, 32'h0);
    bus_read(BASE + 12'h08, d); chk("R1 control B reset", d, 32'h0);
    bus_read(BASE + 12'h4C, d); chk("R1 result reset", d, 32'h0);

    // R2 R3 decode and bit layout
    bus_write(BASE + 12'h04, 32'hFFFF_FFFF);
    bus_read(BASE + 12'h04, d); chk("R3 control A mask", d, 32'h0000_0120);
    bus_write(12'h204, 32'h0);
    bus_write(12'h004, 32'h0);
    bus_read(BASE + 12'h04, d); chk("R2 other window write ignored", d, 32'h0000_0120);
    bus_read(12'h204, d); chk("R2 other window reads 0", d, 32'h0);
    bus_read(BASE + 12'h24, d); chk("R2 unlisted offset reads 0", d, 32'h0);
    bus_write(BASE + 12'h34, 32'hFFFF_FFFF);
    bus_read(BASE + 12'h34, d); chk("R7 sequence 0x34 width", d, 32'h3FFF_FFFF);
    bus_write(BASE + 12'h04, 32'h0);

    // R4 R5 hold-off with pending software start
    n_started = 0; n_done = 0;
    bus_write(BASE + 12'h08, 32'h4000_0401);
    cyc = 0;
    while (!conv_start && cyc < 100) begin @(negedge clk); cyc++; end
    chk("R4 no start during wait", {31'b0, cyc >= STAB}, 32'h1);
    chk("R4 pending start honoured", {31'b0, cyc <= STAB + 2}, 32'h1);
    wait_done(1);
    bus_read(BASE + 12'h4C, d); chk("R8 first result", d, {20'b0, last_res});
    bus_write(BASE + 12'h00, 32'h0);

    // R10 flag write semantics
    bus_write(BASE + 12'h08, 32'h4000_0401);
    wait_done(1);
    bus_write(BASE + 12'h00, 32'h0000_0012);
    bus_read(BASE + 12'h00, d); chk("R10 writing ones keeps flags", d, 32'h12);
    bus_write(BASE + 12'h00, 32'h0000_0002);
    bus_read(BASE + 12'h00, d); chk("R10 writing 0 clears started", d, 32'h02);

    // R11 interrupt gating
    bus_write(BASE + 12'h04, 32'h20);
    @(negedge clk); chk("R11 irq with enable", {31'b0, irq}, 32'h1);
    bus_write(BASE + 12'h04, 32'h0);
    @(negedge clk); chk("R11 irq masked", {31'b0, irq}, 32'h0);
    bus_write(BASE + 12'h04, 32'h20);
    bus_read(BASE + 12'h4C, d);
    @(negedge clk); chk("R11 irq drops on read", {31'b0, irq}, 32'h0);

    // R5 R6 external trigger
    n_started = 0; n_done = 0;
    bus_write(BASE + 12'h08, 32'h5000_0401);
    bus_read(BASE + 12'h08, d); chk("R5 start ignored with trigger", d, 32'h1000_0401);
    repeat (20) @(negedge clk);
    chk("R5 no conversion from ignored start", 32'(n_started), 32'h0);
    @(negedge clk); ext_trig = 1'b1;
    wait_done(1);
    chk("R6 rising edge starts", 32'(n_started), 32'h1);
    @(negedge clk); ext_trig = 1'b0;
    repeat (20) @(negedge clk);
    chk("R6 falling edge ignored in rising mode", 32'(n_started), 32'h1);
    bus_write(BASE + 12'h08, 32'h2000_0401);
    @(negedge clk); ext_trig = 1'b1;
    repeat (10) @(negedge clk);
    chk("R6 rising edge ignored in falling mode", 32'(n_started), 32'h1);
    @(negedge clk); ext_trig = 1'b0;
    wait_done(2);
    chk("R6 falling edge starts", 32'(n_started), 32'h2);
    bus_read(BASE + 12'h4C, d);
    bus_write(BASE + 12'h00, 32'h0);

    // R9 flag select mid-sequence
    for (int m = 0; m < 2; m++) begin
      for (int k = 0; k < 16; k++) s[k] = 5'(k);
      lat = 15;
      bus_write(BASE + 12'h34, pack_seq(3, s, 2));
      bus_write(BASE + 12'h2C, pack_seq(1, s, 2));
      bus_write(BASE + 12'h04, 32'h100);
      n_started = 0; n_done = 0;
      bus_write(BASE + 12'h08, 32'h4000_0001 | (32'(m) << 10));
      for (int i = 0; i < 500 && n_done < 1; i++) @(negedge clk);
      bus_read(BASE + 12'h00, d);
      chk("R9 flag after first of three", d, m ? 32'h12 : 32'h10);
      wait_done(3);
      bus_read(BASE + 12'h4C, d);
      bus_write(BASE + 12'h00, 32'h0);
    end
    lat = 2;

    // R9 collision: result arrives during result read
    auto_en = 0;
    bus_write(BASE + 12'h04, 32'h0);
    bus_write(BASE + 12'h08, 32'h4000_0401);
    for (int i = 0; i < 100 && !conv_start; i++) @(negedge clk);
    @(negedge clk);
    addr = BASE + 12'h4C; rd = 1'b1; conv_done = 1'b1; conv_res = 12'hA5C;
    @(negedge clk);
    rd = 1'b0; conv_done = 1'b0;
    bus_read(BASE + 12'h00, d); chk("R9 set wins over read clear", d, 32'h12);
    bus_read(BASE + 12'h4C, d); chk("R8 collision result stored", d, 32'hA5C);
    bus_write(BASE + 12'h00, 32'h0);
    auto_en = 1;

    // R12 abort
    lat = 30;
    for (int k = 0; k < 16; k++) s[k] = 5'(15 - k);
    bus_write(BASE + 12'h34, pack_seq(3, s, 3));
    bus_write(BASE + 12'h2C, pack_seq(1, s, 3));
    bus_write(BASE + 12'h04, 32'h100);
    n_started = 0; n_done = 0;
    bus_write(BASE + 12'h08, 32'h4000_0001);
    for (int i = 0; i < 100 && n_started < 1; i++) @(negedge clk);
    bus_read(BASE + 12'h00, d); chk("R10 started flag while running", d, 32'h10);
    bus_write(BASE + 12'h08, 32'h0);
    repeat (50) @(negedge clk);
    chk("R12 no start after abort", 32'(n_started), 32'h1);
    bus_read(BASE + 12'h00, d); chk("R12 status cleared on abort", d, 32'h0);
    bus_read(BASE + 12'h4C, d); chk("R12 late result ignored", d, 32'hA5C);
    lat = 2;
    bus_write(BASE + 12'h08, 32'h0000_0001);
    repeat (STAB + 2) @(negedge clk);

    // random sequences
    for (int it = 0; it < 24; it++) begin
      for (int k = 0; k < 16; k++) s[k] = 5'($urandom_range(0, 15));
      lat = $urandom_range(1, 4);
      run_seq(1'($urandom), 1'($urandom), $urandom_range(0, 15), s);
    end

    finished = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual hung expected done");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end
endmodule